// File: doc/BRIEF.md
# SIMD Byte-Align and Immediate-Replicate Unit

This block executes two operations of one sub-opcode group of a 32-bit media SIMD extension in a single cycle. It takes an instruction word, the value of one general-purpose register and a valid strobe. It owns a file of sixteen 32-bit SIMD registers. Register 0 is hard-wired to zero. The result of an accepted instruction is written back into the file on the next rising clock edge.

The first operation is a byte-granular funnel shift. It joins two SIMD registers and extracts a word at a byte offset taken from the general-purpose register. Two offsets pass one source through unchanged, and the offsets above four are undefined. The second operation builds a word from an 8-bit immediate using one of eight lane-placement patterns. A combinational debug port reads any SIMD register, so an external model can compare the whole file after every instruction.

Top module: `simd_align_unit`

## Requirements
- R1: Bits 20:18 of the instruction word select the operation: value 1 is byte-align and value 3 is immediate-replicate. Any other value, and any cycle with valid low, leaves every register unchanged.
- R2: The destination index is in bits 9:6 for both operations. Destination 0 writes nothing, and register 0 always reads as zero.
- R3: For byte-align, the first source index is in bits 13:10, the second source index is in bits 17:14, and the shift amount n is bits 2:0 of the general-purpose input. Higher bits of that input have no effect.
- R4: For byte-align, n = 0 writes the first source unchanged and n = 4 writes the second source unchanged.
- R5: For byte-align with n from 1 to 3, the result is (first << 8n) | (second >> (32 - 8n)).
- R6: For byte-align with n from 5 to 7, the destination keeps its old value, unless R7 applies.
- R7: For byte-align with both source indices 0, the destination is written with zero for every n.
- R8: For immediate-replicate, the byte is in bits 17:10, a padding field is in bits 22:21 and the pattern code is in bits 25:23. A nonzero padding field makes the instruction write nothing.
- R9: Pattern codes 0, 1, 2 and 3 put the byte in lane 0, 1, 2 or 3 (lane k is bits 8k+7:8k), and all other lanes are zero.
- R10: Pattern code 4 puts the byte in lanes 0 and 2. Pattern code 5 puts it in lanes 1 and 3. All other lanes are zero.
- R11: Pattern code 6 sign-extends the byte to 16 bits and places that halfword in both halves. Pattern code 7 copies the byte to all four lanes.
- R12: After reset every register reads zero. A write takes effect on the rising edge after the instruction is presented, and the sources are read before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 32 | Instruction word |
| gprValue | input | 32 | General-purpose register value; bits 2:0 are the align amount |
| dbgIdx | input | 4 | Debug read index |
| dbgData | output | 32 | Contents of the register selected by dbgIdx |

## Verification
A wrong write enable, a wrong lane mask or a wrong funnel offset shows up as a wrong word in one register. The debug port reads that word in the cycle after the instruction. The whole file is compared after each instruction, so a stray write to a register that should not change is also caught at once. Later align sweeps read registers that earlier instructions wrote, so a corrupted value also spreads into later results.

// File: rtl/salu_pkg.sv
package salu_pkg;
  localparam int DATA_W = 32;
  localparam int NREGS  = 16;
  localparam int IDX_W  = $clog2(NREGS);
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    OP_ALIGN = 3'd1,
    OP_REPL  = 3'd3
  } subOp_e;

  typedef struct packed {
    logic             wrEn;
    logic             selRep;
    logic             forceZero;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] srcA;
    logic [IDX_W-1:0] srcB;
    logic [2:0]       shAmt;
    logic [7:0]       imm;
    logic [2:0]       pattern;
  } ctlStrobes_t;
endpackage

// File: rtl/sau_ctrl.sv
module sau_ctrl
  import salu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instrValid,
  input  logic [31:0]       instrWord,
  input  logic [DATA_W-1:0] gprValue,
  output ctlStrobes_t       ctl
);
  logic [2:0] subOp;
  logic       isAlign, isRep, bothZero, alignOk, repOk;
  logic [1:0] padField;

  assign subOp    = instrWord[20:18];
  assign padField = instrWord[22:21];
  assign isAlign  = instrValid && (subOp == OP_ALIGN);
  assign isRep    = instrValid && (subOp == OP_REPL);
  assign bothZero = (instrWord[13:10] == '0) && (instrWord[17:14] == '0);
  assign alignOk  = isAlign && (bothZero || (gprValue[2:0] < 3'd5));
  assign repOk    = isRep && (padField == 2'b00);

  always_comb begin
    ctl.dst       = instrWord[9:6];
    ctl.srcA      = instrWord[13:10];
    ctl.srcB      = instrWord[17:14];
    ctl.shAmt     = gprValue[2:0];
    ctl.imm       = instrWord[17:10];
    ctl.pattern   = instrWord[25:23];
    ctl.selRep    = isRep;
    ctl.forceZero = isAlign && bothZero;
    ctl.wrEn      = (alignOk || repOk) && (instrWord[9:6] != '0);
  end

  AST_OTHER_OPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!instrValid || (instrWord[20:18] != 3'd1 && instrWord[20:18] != 3'd3)) |-> !ctl.wrEn); // R1
  AST_UNDEF_AMOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (instrValid && instrWord[20:18] == 3'd1 && gprValue[2:0] >= 3'd5 &&
     (instrWord[17:10] != 8'h00)) |-> !ctl.wrEn); // R6
  AST_PAD_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (instrValid && instrWord[20:18] == 3'd3 && instrWord[22:21] != 2'b00) |-> !ctl.wrEn); // R8
endmodule

// File: rtl/sau_dpath.sv
module sau_dpath
  import salu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       ctl,
  input  logic [IDX_W-1:0]  dbgIdx,
  output logic [DATA_W-1:0] dbgData
);
  logic [DATA_W-1:0]   view [NREGS];
  logic [DATA_W-1:0]   opA, opB, alignWord, repWord, result;
  logic [2*DATA_W-1:0] funnel;
  logic [LANES-1:0]    laneOn;

  genvar gi;
  generate
    for (gi = 0; gi < NREGS; gi++) begin : g_reg
      if (gi == 0) begin : g_zero
        assign view[gi] = '0;
      end else begin : g_store
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
          if (!rst_n) q <= '0;
          else if (ctl.wrEn && ctl.dst == IDX_W'(gi)) q <= result;
        end
        assign view[gi] = q;
      end
    end
  endgenerate

  assign opA     = view[ctl.srcA];
  assign opB     = view[ctl.srcB];
  assign dbgData = view[dbgIdx];

  assign funnel = {opA, opB} << {ctl.shAmt, 3'b000};

  always_comb begin
    case (ctl.shAmt)
      3'd0:    alignWord = opA;
      3'd4:    alignWord = opB;
      3'd1, 3'd2, 3'd3: alignWord = funnel[2*DATA_W-1:DATA_W];
      default: alignWord = opA;
    endcase
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      case (ctl.pattern)
        3'd4:    laneOn[k] = (k % 2 == 0);
        3'd5:    laneOn[k] = (k % 2 == 1);
        3'd6, 3'd7: laneOn[k] = 1'b1;
        default: laneOn[k] = (ctl.pattern[1:0] == 2'(k));
      endcase
    end
  end

  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      logic [7:0] laneVal;
      assign laneVal = (ctl.pattern == 3'd6 && (gi % 2 == 1)) ? {8{ctl.imm[7]}} : ctl.imm;
      assign repWord[8*gi +: 8] = laneOn[gi] ? laneVal : 8'h00;
    end
  endgenerate

  assign result = ctl.selRep ? repWord : (ctl.forceZero ? '0 : alignWord);

  AST_DST0_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.wrEn |-> (ctl.dst != '0)); // R2
  AST_WRITE_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.wrEn |=> (view[$past(ctl.dst)] == $past(result))); // R12
  AST_BOTH_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.wrEn && ctl.forceZero) |=> (view[$past(ctl.dst)] == '0)); // R7
endmodule

// File: rtl/simd_align_unit.sv
module simd_align_unit
  import salu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instrValid,
  input  logic [31:0] instrWord,
  input  logic [31:0] gprValue,
  input  logic [3:0]  dbgIdx,
  output logic [31:0] dbgData
);
  ctlStrobes_t ctl;

  sau_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .gprValue   (gprValue),
    .ctl        (ctl)
  );

  sau_dpath u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .dbgIdx  (dbgIdx),
    .dbgData (dbgData)
  );

  AST_REG0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dbgIdx == 4'd0) |-> (dbgData == 32'h0)); // R2
endmodule

// File: tb/tb_simd_align_unit.sv
`timescale 1ns/1ps
module tb_simd_align_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] gprValue = '0;
  logic [3:0]  dbgIdx = '0;
  logic [31:0] dbgData;

  logic [31:0] mdl [16];
  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  simd_align_unit dut (
    .clk(clk), .rst_n(rst_n), .instrValid(instrValid), .instrWord(instrWord),
    .gprValue(gprValue), .dbgIdx(dbgIdx), .dbgData(dbgData)
  );

  function automatic logic [31:0] mkAlign(int d, int a, int b, logic [2:0] op);
    logic [31:0] w;
    w = 32'hA8000000;
    w[20:18] = op; w[17:14] = 4'(b); w[13:10] = 4'(a); w[9:6] = 4'(d);
    return w;
  endfunction

  function automatic logic [31:0] mkRep(int d, logic [7:0] v, int pad, int pat);
    logic [31:0] w;
    w = 32'h5C00002D;
    w[25:23] = 3'(pat); w[22:21] = 2'(pad); w[20:18] = 3'd3; w[17:10] = v; w[9:6] = 4'(d);
    return w;
  endfunction

  function automatic logic [31:0] expRep(logic [7:0] v, int pat);
    logic [31:0] x, h;
    x = {24'h0, v};
    h = {16'h0, {8{v[7]}}, v};
    case (pat)
      0: return x;
      1: return x << 8;
      2: return x << 16;
      3: return x << 24;
      4: return (x << 16) | x;
      5: return (x << 24) | (x << 8);
      6: return (h << 16) | h;
      default: return x * 32'h01010101;
    endcase
  endfunction

  function automatic logic [31:0] expAlign(logic [31:0] a, logic [31:0] b, int n);
    if (n == 0) return a;
    if (n == 4) return b;
    return (a << (8 * n)) | (b >> (32 - 8 * n));
  endfunction

  task automatic checkFile(string tag);
    for (int i = 0; i < 16; i++) begin
      dbgIdx = 4'(i);
      #0.2;
      vectors++;
      if (dbgData !== mdl[i]) begin
        miscompares++;
        $display("FAIL %s reg%0d got %h exp %h", tag, i, dbgData, mdl[i]);
      end
    end
  endtask

  task automatic issue(logic [31:0] w, logic [31:0] g, string tag);
    @(negedge clk);
    instrWord = w; gprValue = g; instrValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instrValid = 1'b0;
    instrWord = 32'hFFFFFFFF;
    checkFile(tag);
  endtask

  task automatic doRep(int d, logic [7:0] v, int pad, int pat);
    string tag;
    if (pad != 0) tag = "R8";
    else if (pat < 4) tag = "R9";
    else if (pat < 6) tag = "R10";
    else tag = "R11";
    if (d == 0) tag = {tag, " R2"};
    if (pad == 0 && d != 0) mdl[d] = expRep(v, pat);
    issue(mkRep(d, v, pad, pat), 32'h0, tag);
  endtask

  task automatic doAlign(int d, int a, int b, int n, logic [28:0] hi);
    string tag;
    logic [31:0] va, vb;
    va = mdl[a]; vb = mdl[b];
    if (a == 0 && b == 0) tag = "R7";
    else if (n == 0 || n == 4) tag = "R4 R3";
    else if (n < 4) tag = "R5 R3";
    else tag = "R6";
    if (d == 0) tag = {tag, " R2"};
    if (d != 0) begin
      if (a == 0 && b == 0) mdl[d] = 32'h0;
      else if (n < 5) mdl[d] = expAlign(va, vb, n);
    end
    issue(mkAlign(d, a, b, 3'd1), {hi, 3'(n)}, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R12 watchdog expired got running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    checkFile("R12 reset");

    // seed distinct contents
    for (int d = 1; d < 16; d++) doRep(d, 8'(d * 37 + 5), 0, 7);
    // pattern sweep including padding and destination 0
    for (int pat = 0; pat < 8; pat++)
      for (int pad = 0; pad < 4; pad++)
        for (int j = 0; j < 6; j++)
          doRep((pat * 5 + pad * 3 + j) % 16, 8'(j * 71 + pat * 13 + 128 * (j % 2)), pad, pat);
    // reseed with sign-rich data
    for (int d = 1; d < 16; d++) doRep(d, 8'(d * 53 + 129), 0, d % 8);
    // R1: other sub-opcodes and valid low have no effect
    for (int op = 0; op < 8; op++)
      if (op != 1 && op != 3) issue(mkAlign(op + 2, 5, 6, 3'(op)), 32'h1, "R1");
    @(negedge clk);
    instrWord = mkRep(4, 8'h5A, 0, 7); gprValue = 0; instrValid = 1'b0;
    @(posedge clk); @(negedge clk);
    checkFile("R1 valid low");
    // R12: destination equals a source reads the pre-write value
    doAlign(3, 3, 7, 1, 29'h0);
    doAlign(9, 2, 9, 3, 29'h0);
    // exhaustive align sweep
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int n = 0; n < 8; n++)
          doAlign((a * 3 + b * 5 + n * 7) % 16, a, b, n, 29'((a * 1000003 + b * 7919 + n) * 97));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule